// File: doc/BRIEF.md
# Fast-Lock Synthesizer Programming Sequencer

This block programs a fractional-N frequency synthesizer so that it enters fast-lock mode. A start command launches a fixed series of five 24-bit register writes. Each word is assembled from fields supplied by the user and shifted out over a three-wire serial link made of a serial clock, a data line and a latch strobe.

The series writes the reference-divider register twice. The first write loads the fast-lock timer value in place of the modulus. The second write restores the modulus and routes the fast-lock switch to the multiplexer output. Between these two writes the series sends the noise/spur word and the control word, and it ends with the N-divider word, which has its fast-lock bit set.

Once the full series has run, a hop command sends only the N-divider word. The block fills in only the bits that the sequence itself dictates: the register address in bits 1:0, the load-control bit, the multiplexer code, the timer or modulus field, and the fast-lock bit. Every other bit is passed through from the user's words.

Top module: `synth_prog_seq`

## Requirements
- R1: Word 1 of the full series is the reference-divider word with bit 23 = 1, bits 22:14 taken from `rdiv_word_i[22:14]`, bits 13:2 = `timer_i` and address bits 1:0 = 01.
- R2: Word 2 is `noise_word_i[23:2]` with address 11, and word 3 is `ctrl_word_i[23:2]` with address 10, in that order.
- R3: Word 4 is the reference-divider word with bit 23 = 0, bits 22:20 = 110, bits 19:14 taken from `rdiv_word_i[19:14]`, bits 13:2 = `mod_i` and address 01.
- R4: Word 5 is `ndiv_word_i[22:2]` with bit 23 = 1 (fast lock) and address 00.
- R5: A hop request made after a full series has completed sends exactly one word, the word 5 form, built from the current `ndiv_word_i`.
- R6: Each word is shifted MSB first, one bit per serial clock period, with data sampled on the rising edge of `ser_clk_o` and held steady while the clock is high. After bit 0, `ser_le_o` is high for one serial period (2*CLK_DIV clocks) while `ser_clk_o` is low.
- R7: `busy_o` rises on the clock edge that accepts a command and falls on the edge that ends the final latch pulse. While `busy_o` is low, `ser_clk_o` and `ser_le_o` are low.
- R8: Start and hop requests made while `busy_o` is high are ignored. This holds for their field values as well: they do not change the words in flight.
- R9: A hop request made before any full series has completed runs the full five-word series.
- R10: After reset, `busy_o`, `ser_clk_o`, `ser_data_o` and `ser_le_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request the full five-word series |
| hop_i | input | 1 | Request an N-divider-only update |
| timer_i | input | 12 | Fast-lock timer value (PFD cycles) |
| mod_i | input | 12 | Fractional modulus |
| rdiv_word_i | input | 24 | User reference-divider word (bits 22:14 used) |
| noise_word_i | input | 24 | User noise/spur word (bits 23:2 used) |
| ctrl_word_i | input | 24 | User control word (bits 23:2 used) |
| ndiv_word_i | input | 24 | User N-divider word (bits 22:2 used) |
| ser_clk_o | output | 1 | Serial clock |
| ser_data_o | output | 1 | Serial data, MSB first |
| ser_le_o | output | 1 | Latch strobe |
| busy_o | output | 1 | Series in progress |

## Verification
A wrong step counter shows up at the latch strobe. Words then arrive in the wrong order or in the wrong number, or carry the wrong address bits, so a mismatch is visible within one word time (about 50*CLK_DIV clocks) of the fault. A wrong "series completed" flag makes a hop send five words instead of one, or one word instead of five, and this is seen at the first latch pulse of that hop. A bit-counter or divider fault distorts the recovered word or the strobe width within the same word.

// File: rtl/synth_prog_seq.sv
module synth_prog_seq #(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        hop_i,
  input  logic [11:0] timer_i,
  input  logic [11:0] mod_i,
  input  logic [23:0] rdiv_word_i,
  input  logic [23:0] noise_word_i,
  input  logic [23:0] ctrl_word_i,
  input  logic [23:0] ndiv_word_i,
  output logic        ser_clk_o,
  output logic        ser_data_o,
  output logic        ser_le_o,
  output logic        busy_o
);
  localparam int CW       = $clog2(2 * CLK_DIV) + 1;
  localparam int LAST_BIT = 23;
  localparam logic [2:0] LAST_STEP = 3'd4;
  localparam logic [CW-1:0] HALF_END = CW'(CLK_DIV - 1);
  localparam logic [CW-1:0] LE_END   = CW'(2 * CLK_DIV - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_LATCH} st_t;

  st_t          st;
  logic [2:0]   step;
  logic [4:0]   bitn;
  logic [CW-1:0] cnt;
  logic [23:0]  sh;
  logic         sclk_q, le_q, inited;
  logic [11:0]  c_tmr, c_mod;
  logic [23:0]  c_r, c_ns, c_ctl, c_n;

  function automatic logic [23:0] build(
    input logic [2:0]  s,
    input logic [11:0] tmr,
    input logic [11:0] md,
    input logic [23:0] r,
    input logic [23:0] ns,
    input logic [23:0] ctl,
    input logic [23:0] n
  );
    case (s)
      3'd0:    build = {1'b1, r[22:14], tmr, 2'b01};
      3'd1:    build = {ns[23:2], 2'b11};
      3'd2:    build = {ctl[23:2], 2'b10};
      3'd3:    build = {1'b0, 3'b110, r[19:14], md, 2'b01};
      default: build = {1'b1, n[22:2], 2'b00};
    endcase
  endfunction

  wire       accept   = (st == S_IDLE) && (start_i || hop_i);
  wire       full_run = start_i || !inited;
  wire [2:0] first    = full_run ? 3'd0 : LAST_STEP;

  assign ser_clk_o  = sclk_q;
  assign ser_data_o = (st == S_SHIFT) ? sh[23] : 1'b0;
  assign ser_le_o   = le_q;
  assign busy_o     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      step   <= '0;
      bitn   <= '0;
      cnt    <= '0;
      sh     <= '0;
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
      inited <= 1'b0;
      c_tmr  <= '0;
      c_mod  <= '0;
      c_r    <= '0;
      c_ns   <= '0;
      c_ctl  <= '0;
      c_n    <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          c_tmr  <= timer_i;
          c_mod  <= mod_i;
          c_r    <= rdiv_word_i;
          c_ns   <= noise_word_i;
          c_ctl  <= ctrl_word_i;
          c_n    <= ndiv_word_i;
          step   <= first;
          sh     <= build(first, timer_i, mod_i, rdiv_word_i,
                          noise_word_i, ctrl_word_i, ndiv_word_i);
          bitn   <= '0;
          cnt    <= '0;
          sclk_q <= 1'b0;
          st     <= S_SHIFT;
        end
        S_SHIFT: begin
          if (cnt == HALF_END) begin
            cnt <= '0;
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else begin
              sclk_q <= 1'b0;
              if (bitn == 5'(LAST_BIT)) begin
                le_q <= 1'b1;
                st   <= S_LATCH;
              end else begin
                sh   <= {sh[22:0], 1'b0};
                bitn <= bitn + 5'd1;
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_LATCH: begin
          if (cnt == LE_END) begin
            cnt  <= '0;
            le_q <= 1'b0;
            if (step == LAST_STEP) begin
              inited <= 1'b1;
              st     <= S_IDLE;
            end else begin
              step <= step + 3'd1;
              sh   <= build(step + 3'd1, c_tmr, c_mod, c_r, c_ns, c_ctl, c_n);
              bitn <= '0;
              st   <= S_SHIFT;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module synth_prog_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ser_clk_o,
  input logic ser_data_o,
  input logic ser_le_o,
  input logic busy_o
);
  a_r6_le_with_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le_o |-> !ser_clk_o);
  a_r6_data_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk_o |-> $stable(ser_data_o));
  a_r7_le_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le_o |-> busy_o);
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!ser_clk_o && !ser_le_o));
  a_r7_busy_ends_on_le: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(ser_le_o));
  a_r10_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!busy_o && !ser_clk_o && !ser_le_o && !ser_data_o));
endmodule

bind synth_prog_seq synth_prog_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ser_clk_o(ser_clk_o),
  .ser_data_o(ser_data_o), .ser_le_o(ser_le_o), .busy_o(busy_o)
);

// File: tb/synth_prog_seq_tb.sv
module synth_prog_seq_tb;
  localparam int DIV = 2;

  logic clk = 0, rst_n = 0, start_i = 0, hop_i = 0;
  logic [11:0] timer_i = 12'd520, mod_i = 12'd4000;
  logic [23:0] rdiv_word_i = 24'hA5C3F7, noise_word_i = 24'h3C96A5;
  logic [23:0] ctrl_word_i = 24'h5A0F1E, ndiv_word_i = 24'h12345B;
  logic ser_clk_o, ser_data_o, ser_le_o, busy_o;

  int checks = 0, fails = 0;
  logic [23:0] rx [0:63];
  int nrx = 0, nbits = 0, le_cnt = 0, last_le = 0;
  logic [23:0] shreg = '0;

  always #4 clk = ~clk;

  synth_prog_seq #(.CLK_DIV(DIV)) u_dut (.*);

  always @(posedge ser_clk_o) begin
    shreg <= {shreg[22:0], ser_data_o};
    nbits <= nbits + 1;
  end
  always @(posedge ser_le_o) begin
    if (nrx < 64) rx[nrx] = shreg;
    nrx = nrx + 1;
    if (nbits != 24) begin
      fails++; $display("FAIL R6 bits per word got %0d exp 24", nbits);
    end
    checks++;
    nbits = 0;
  end
  always @(negedge clk) begin
    if (ser_le_o) le_cnt++;
    else if (le_cnt != 0) begin last_le = le_cnt; le_cnt = 0; end
  end

  task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [23:0] exp_w(input int s);
    logic [23:0] e;
    case (s)
      0: begin e = rdiv_word_i; e[23] = 1'b1; e[13:2] = timer_i; e[1:0] = 2'b01; end
      1: begin e = noise_word_i; e[1:0] = 2'b11; end
      2: begin e = ctrl_word_i; e[1:0] = 2'b10; end
      3: begin e = rdiv_word_i; e[23:20] = 4'b0110; e[13:2] = mod_i; e[1:0] = 2'b01; end
      default: begin e = ndiv_word_i; e[23] = 1'b1; e[1:0] = 2'b00; end
    endcase
    return e;
  endfunction

  task automatic issue(input logic s, input logic h);
    @(negedge clk); start_i = s; hop_i = h;
    @(negedge clk); start_i = 0; hop_i = 0;
    chk("R7 busy after accept", 24'(busy_o), 24'd1);
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    chk("R7 idle outputs", {21'd0, ser_clk_o, ser_le_o, busy_o}, 24'd0);
  endtask

  task automatic check_full(input string tag, input int base);
    chk({tag, " R9/R5 word count"}, 24'(nrx - base), 24'd5);
    chk({tag, " R1 word1"}, rx[base],   exp_w(0));
    chk({tag, " R2 word2"}, rx[base+1], exp_w(1));
    chk({tag, " R2 word3"}, rx[base+2], exp_w(2));
    chk({tag, " R3 word4"}, rx[base+3], exp_w(3));
    chk({tag, " R4 word5"}, rx[base+4], exp_w(4));
  endtask

  task automatic t_reset();
    chk("R10 reset outputs", {20'd0, busy_o, ser_clk_o, ser_data_o, ser_le_o}, 24'd0);
  endtask

  task automatic t_hop_cold();
    int b = nrx;
    issue(0, 1); wait_idle();
    check_full("R9 cold hop", b);
    chk("R6 latch width", 24'(last_le), 24'(2*DIV));
  endtask

  task automatic t_start_full();
    int b;
    timer_i = 12'hFFF; mod_i = 12'h001; rdiv_word_i = 24'h5A3C0E;
    noise_word_i = 24'hFFFFFC; ctrl_word_i = 24'h000003; ndiv_word_i = 24'h7FFFFF;
    b = nrx;
    issue(1, 0); wait_idle();
    check_full("R1 start", b);
  endtask

  task automatic t_hop_warm();
    int b;
    ndiv_word_i = 24'h0ABCDE;
    b = nrx;
    issue(0, 1); wait_idle();
    chk("R5 hop word count", 24'(nrx - b), 24'd1);
    chk("R5 hop word", rx[b], exp_w(4));
    ndiv_word_i = 24'h800001;
    b = nrx;
    issue(0, 1); wait_idle();
    chk("R5 second hop", rx[b], exp_w(4));
  endtask

  task automatic t_busy_ignore();
    int b;
    logic [23:0] keep;
    ndiv_word_i = 24'h246801;
    keep = exp_w(4);
    b = nrx;
    issue(1, 0);
    repeat (40) @(negedge clk);
    ndiv_word_i = 24'h13579B; hop_i = 1; start_i = 1;
    @(negedge clk); hop_i = 0; start_i = 0;
    repeat (150) @(negedge clk);
    hop_i = 1;
    @(negedge clk); hop_i = 0;
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R8 ignored requests word count", 24'(nrx - b), 24'd5);
    chk("R8 word5 unchanged", rx[b+4], keep);
    chk("R8 still idle", 24'(busy_o), 24'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_hop_cold();
    t_start_full();
    t_hop_warm();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule